// File: doc/BRIEF.md
# 1-Wire Device Identifier Enumerator

This block walks a 1-Wire bus and collects the 64-bit identifiers of the devices attached to it, up to a table of parameterised depth. It does not drive the wire itself. It asks a lower-level bus engine for three primitives through a request/acknowledge pair: a bus reset that reports whether any device answered, a byte write, and a search triplet. The triplet reads two bits, writes one direction bit and reports the direction that was actually taken.

A search is started with a pulse on `start` and takes a family filter and a table limit. Each pass resets the bus, writes the search command byte and then runs 64 triplets, one per identifier bit. The direction for each bit comes from the family filter, from a replay of the previous identifier below the last collision point, or from a fresh choice at that point. A finished pass is stored only if its check byte is correct. A lost device or a bad check byte restarts the pass for the same slot, up to a retry cap. When the search stops, `done` pulses. The count, the error flag and the table then stay readable until the next start.

Top module: `idscan_ctrl`

## Requirements
- R1: A `start` taken while idle with an effective limit of at least 1 raises `prim_req` with `prim_op` = 0 (bus reset) in the next cycle. A `start` while `busy` is high is ignored and does not change the running search or its results.
- R2: If a bus reset returns `prim_presence` = 0, the search ends with `done`, `err` = 0 and the count found so far.
- R3: After a bus reset with presence, the block writes byte 0xF0 (`prim_op` = 1) and then issues 64 triplets (`prim_op` = 2). The direction taken by triplet k (k = 1..64) is stored as identifier bit k-1, so bit 0 of byte 0 comes first.
- R4: With a nonzero `family` input, the direction requested in triplets 1 to 8 is bit (k-1) of `family`. Only devices of that family are enumerated, provided the filter takes no zero branch at a collision.
- R5: Without a filter, the direction below the last collision index replays the previous identifier's bit, is 1 at that index and is 0 above it. Each device therefore appears once, in ascending order of its bit-reversed identifier, and the count rises by exactly 1 per stored identifier.
- R6: A triplet that returns both read bits as 1 abandons the pass. The block issues a new bus reset for the same slot.
- R7: When the filter is active and a triplet in bits 1 to 8 takes a direction different from the one requested, the search ends with `err` = 0.
- R8: A pass is stored only if byte 7 equals the CRC-8 of bytes 0 to 6 (polynomial x^8+x^5+x^4+1, least significant bit first, initial value 0). A pass that fails this check counts as a restart.
- R9: After RETRY_MAX restarts of one slot, a further restart ends the search with `err` = 1, and `err` rises together with `done`.
- R10: The search ends once the count reaches min(`limit`, N_IDS), or after a stored pass that recorded no collision. A `limit` of 0 ends it at once with no bus request. The count never exceeds the effective limit.
- R11: `prim_req` stays high with `prim_op` and `prim_dir` unchanged until the cycle in which `prim_ack` is high.
- R12: After reset, `busy`, `done`, `err`, `count` and `prim_req` are 0. `done` is a one-cycle pulse. `count`, `err` and the table hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| family | input | 8 | Family filter, 0 disables it |
| limit | input | CW | Maximum identifiers to collect |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the search ends |
| err | output | 1 | Retry cap exceeded in the last search |
| count | output | CW | Identifiers stored |
| rd_slot | input | SW | Table read index |
| rd_id | output | 64 | Identifier at `rd_slot` |
| prim_req | output | 1 | Primitive request |
| prim_op | output | 2 | 0 bus reset, 1 byte write, 2 triplet |
| prim_wdata | output | 8 | Byte for the write primitive |
| prim_dir | output | 1 | Requested triplet direction |
| prim_ack | input | 1 | Primitive finished, response valid |
| prim_presence | input | 1 | Bus reset saw a device |
| prim_b1 | input | 1 | Triplet first read bit |
| prim_b2 | input | 1 | Triplet second (complement) read bit |
| prim_taken | input | 1 | Direction the triplet actually took |

## Verification
The bus request is due one clock after an accepted start. The bench drives `start` at a falling edge and checks `prim_req`/`prim_op` at the next falling edge. Every primitive response is consumed on the clock edge where `prim_ack` is high. `done` follows one clock after the final bus-reset or triplet acknowledge, or two clocks after the 64th triplet acknowledge, because one cycle is spent on the check byte. The bench therefore waits at falling edges for `done`, reads `count`, `err` and the table in that cycle, and watches four more cycles for a stray second pulse. The bus model answers after a latency that varies from zero to two cycles, so the handshake and the cycle counts do not depend on a fixed response time.

// File: rtl/idscan_pkg.sv
package idscan_pkg;

  typedef enum logic [1:0] {
    OP_BUSRST  = 2'd0,
    OP_WRBYTE  = 2'd1,
    OP_TRIPLET = 2'd2
  } prim_op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_CMD, S_TRI, S_CHK
  } seq_state_t;

  localparam logic [7:0] SEARCH_CMD = 8'hF0;

  // Reflected CRC-8 (x^8+x^5+x^4+1), lsb first, zero start
  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  // Direction rule for bit index k (1..64)
  function automatic logic pick_dir(input logic [6:0] k, input logic [7:0] fam,
                                    input logic prev_bit, input logic prev_ok,
                                    input logic [6:0] last);
    if (fam != 8'h00 && k <= 7'd8) return fam[k[2:0] - 3'd1];
    else if (prev_ok && k < last)  return prev_bit;
    else                           return (k == last);
  endfunction

endpackage

// File: rtl/idscan_dirsel.sv
module idscan_dirsel
  import idscan_pkg::*;
(
  input  logic [6:0]  idx,
  input  logic [7:0]  fam,
  input  logic [63:0] prev_id,
  input  logic        prev_ok,
  input  logic [6:0]  last,
  output logic        dir
);
  logic [5:0] bpos;
  assign bpos = idx[5:0] - 6'd1;
  assign dir  = pick_dir(idx, fam, prev_id[bpos], prev_ok, last);
endmodule

// File: rtl/idscan_crc.sv
module idscan_crc
  import idscan_pkg::*;
(
  input  logic [63:0] id,
  output logic        ok
);
  assign ok = (crc8_lsb(id[55:0]) == id[63:56]);
endmodule

// File: rtl/idscan_table.sv
module idscan_table #(
  parameter int N_IDS = 4,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [63:0]   wdata,
  input  logic [SW-1:0] rslot,
  output logic [63:0]   rdata
);
  logic [63:0] ent [N_IDS];

  for (genvar g = 0; g < N_IDS; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ent[g] <= '0;
      else if (we && wslot == SW'(g))    ent[g] <= wdata;
    end
  end

  assign rdata = ent[rslot];
endmodule

// File: rtl/idscan_ctrl.sv
module idscan_ctrl
  import idscan_pkg::*;
#(
  parameter  int N_IDS     = 4,
  parameter  int RETRY_MAX = 3,
  localparam int CW        = $clog2(N_IDS + 1),
  localparam int SW        = (N_IDS > 1) ? $clog2(N_IDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    family,
  input  logic [CW-1:0] limit,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] count,
  input  logic [SW-1:0] rd_slot,
  output logic [63:0]   rd_id,
  output logic          prim_req,
  output logic [1:0]    prim_op,
  output logic [7:0]    prim_wdata,
  output logic          prim_dir,
  input  logic          prim_ack,
  input  logic          prim_presence,
  input  logic          prim_b1,
  input  logic          prim_b2,
  input  logic          prim_taken
);
  localparam int RW = $clog2(RETRY_MAX + 1) > 0 ? $clog2(RETRY_MAX + 1) : 1;

  seq_state_t    state;
  logic [6:0]    bit_idx, last_col, zlast;
  logic [63:0]   cur_id, prev_id;
  logic [CW-1:0] lim_q, lim_c;
  logic [7:0]    fam_q;
  logic [RW-1:0] retries;
  logic          dir_c, crc_ok;

  // Named events for the checker and for readability
  logic start_go, tri_ack, lost_evt, fam_miss_evt, collide_evt;
  logic accept_evt, crc_fail_evt, give_up;

  assign lim_c        = (limit > CW'(N_IDS)) ? CW'(N_IDS) : limit;
  assign start_go     = start && (state == S_IDLE);
  assign tri_ack      = (state == S_TRI) && prim_ack;
  assign lost_evt     = tri_ack && prim_b1 && prim_b2;
  assign fam_miss_evt = tri_ack && !lost_evt && (fam_q != 8'h00) &&
                        (bit_idx <= 7'd8) && (prim_taken != dir_c);
  assign collide_evt  = tri_ack && !prim_taken && !prim_b1 && !prim_b2;
  assign accept_evt   = (state == S_CHK) && crc_ok;
  assign crc_fail_evt = (state == S_CHK) && !crc_ok;
  assign give_up      = (retries == RW'(RETRY_MAX));

  idscan_dirsel u_dir (
    .idx(bit_idx), .fam(fam_q), .prev_id(prev_id),
    .prev_ok(count != '0), .last(last_col), .dir(dir_c)
  );

  idscan_crc u_crc (.id(cur_id), .ok(crc_ok));

  idscan_table #(.N_IDS(N_IDS), .SW(SW)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(accept_evt), .wslot(count[SW-1:0]),
    .wdata(cur_id), .rslot(rd_slot), .rdata(rd_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_idx  <= '0;
      cur_id   <= '0;
      prev_id  <= '0;
      last_col <= '0;
      zlast    <= '0;
      count    <= '0;
      lim_q    <= '0;
      fam_q    <= '0;
      retries  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start_go) begin
          count    <= '0;
          err      <= 1'b0;
          last_col <= '0;
          retries  <= '0;
          fam_q    <= family;
          lim_q    <= lim_c;
          if (lim_c == '0) done  <= 1'b1;
          else             state <= S_RST;
        end
        S_RST: if (prim_ack) begin
          if (!prim_presence) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_CMD;
          end
        end
        S_CMD: if (prim_ack) begin
          bit_idx <= 7'd1;
          zlast   <= '0;
          state   <= S_TRI;
        end
        S_TRI: if (prim_ack) begin
          if (lost_evt) begin
            if (give_up) begin
              err   <= 1'b1;
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              retries <= retries + RW'(1);
              state   <= S_RST;
            end
          end else if (fam_miss_evt) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur_id[bit_idx[5:0] - 6'd1] <= prim_taken;
            if (collide_evt) zlast <= bit_idx;
            if (bit_idx == 7'd64) state   <= S_CHK;
            else                  bit_idx <= bit_idx + 7'd1;
          end
        end
        S_CHK: begin
          if (crc_ok) begin
            count    <= count + CW'(1);
            prev_id  <= cur_id;
            last_col <= zlast;
            retries  <= '0;
            if (zlast == '0 || (count + CW'(1)) == lim_q) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_RST;
            end
          end else if (give_up) begin
            err   <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            retries <= retries + RW'(1);
            state   <= S_RST;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    prim_req   = 1'b0;
    prim_op    = OP_BUSRST;
    prim_wdata = 8'h00;
    prim_dir   = 1'b0;
    unique case (state)
      S_RST: prim_req = 1'b1;
      S_CMD: begin
        prim_req   = 1'b1;
        prim_op    = OP_WRBYTE;
        prim_wdata = SEARCH_CMD;
      end
      S_TRI: begin
        prim_req = 1'b1;
        prim_op  = OP_TRIPLET;
        prim_dir = dir_c;
      end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/idscan_chk.sv
module idscan_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          prim_req,
  input logic          prim_ack,
  input logic [1:0]    prim_op,
  input logic          prim_dir,
  input logic [CW-1:0] count,
  input logic [CW-1:0] lim_q
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_req && !prim_ack) |=> (prim_req && $stable(prim_op) && $stable(prim_dir)));

  p_start_kick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ((prim_req && prim_op == 2'd0) || done));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= lim_q);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == CW'($past(count) + 1'b1) || count == '0));

  p_err_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind idscan_ctrl idscan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .prim_req(prim_req), .prim_ack(prim_ack), .prim_op(prim_op),
  .prim_dir(prim_dir), .count(count), .lim_q(lim_q)
);

// File: tb/sim_idscan_ctrl.sv
module sim_idscan_ctrl;
  localparam int N_IDS = 4;
  localparam int RETRY_MAX = 3;
  localparam int CW = $clog2(N_IDS + 1);
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] family = 8'h00;
  logic [CW-1:0] limit = '0;
  logic busy, done, err;
  logic [CW-1:0] count;
  logic [SW-1:0] rd_slot = '0;
  logic [63:0] rd_id;
  logic prim_req, prim_dir;
  logic [1:0] prim_op;
  logic [7:0] prim_wdata;
  logic prim_ack = 1'b0, prim_presence = 1'b0, prim_b1 = 1'b0, prim_b2 = 1'b0, prim_taken = 1'b0;

  always #10 clk = ~clk;

  idscan_ctrl #(.N_IDS(N_IDS), .RETRY_MAX(RETRY_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .family(family), .limit(limit),
    .busy(busy), .done(done), .err(err), .count(count), .rd_slot(rd_slot),
    .rd_id(rd_id), .prim_req(prim_req), .prim_op(prim_op), .prim_wdata(prim_wdata),
    .prim_dir(prim_dir), .prim_ack(prim_ack), .prim_presence(prim_presence),
    .prim_b1(prim_b1), .prim_b2(prim_b2), .prim_taken(prim_taken)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // bus model state
  logic [63:0] dev [8];
  bit          act [8];
  int ndev = 0, tri_k = 0, lose_at = -1;
  int n_resets = 0, n_tri = 0, bad_cmd = 0, hold_bad = 0, n_req = 0;

  logic [63:0] exp_ids [8];
  int nexp = 0;
  int got_count = 0, got_err = 0, n_done = 0;

  task automatic chk(input string what, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  // CRC-8 via the non-reflected form (poly 0x31) on reflected bytes
  function automatic logic [7:0] crc_ref(input logic [55:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int by = 0; by < 7; by++) begin
      c = c ^ rev8(d[8*by +: 8]);
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h31) : (c << 1);
    end
    return rev8(c);
  endfunction

  function automatic logic [63:0] mk_id(input logic [7:0] fam, input logic [47:0] ser);
    logic [55:0] body;
    body = {ser, fam};
    return {crc_ref(body), body};
  endfunction

  function automatic logic [63:0] rev64(input logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[63-i] = x[i];
    return r;
  endfunction

  task automatic build_exp(input logic [7:0] f);
    logic [63:0] t;
    nexp = 0;
    for (int i = 0; i < ndev; i++)
      if (f == 8'h00 || dev[i][7:0] == f) begin exp_ids[nexp] = dev[i]; nexp++; end
    for (int a = 0; a < nexp; a++)
      for (int b = 0; b < nexp - 1 - a; b++)
        if (rev64(exp_ids[b]) > rev64(exp_ids[b+1])) begin
          t = exp_ids[b]; exp_ids[b] = exp_ids[b+1]; exp_ids[b+1] = t;
        end
  endtask

  task automatic serve(input logic [1:0] op, input logic d);
    logic has0, has1, b1, b2, tk;
    case (op)
      2'd0: begin
        n_resets++;
        for (int i = 0; i < 8; i++) act[i] = (i < ndev);
        tri_k = 0;
        prim_presence = (ndev > 0);
      end
      2'd1: if (prim_wdata !== 8'hF0) bad_cmd++;
      default: begin
        has0 = 0; has1 = 0;
        for (int i = 0; i < ndev; i++)
          if (act[i]) begin
            if (dev[i][tri_k]) has1 = 1; else has0 = 1;
          end
        b1 = !has0; b2 = !has1;
        if (b1 != b2)     tk = b1;
        else if (!b1)     tk = d;
        else              tk = 1'b1;
        if (lose_at == tri_k) begin b1 = 1; b2 = 1; tk = 1; lose_at = -1; end
        for (int i = 0; i < ndev; i++) if (dev[i][tri_k] != tk) act[i] = 0;
        prim_b1 = b1; prim_b2 = b2; prim_taken = tk;
        tri_k++; n_tri++;
      end
    endcase
  endtask

  // primitive responder with latency 0..2
  initial begin
    logic [1:0] op0;
    logic d0;
    forever begin
      @(negedge clk);
      prim_ack = 1'b0;
      if (rst_n && prim_req) begin
        op0 = prim_op; d0 = prim_dir;
        repeat (n_req % 3) begin
          @(negedge clk);
          if (prim_op !== op0 || prim_dir !== d0 || !prim_req) hold_bad++;
        end
        n_req++;
        serve(op0, d0);
        prim_ack = 1'b1;
      end
    end
  end

  task automatic run(input logic [7:0] f, input logic [CW-1:0] lim, input int poke);
    int cyc;
    n_resets = 0; n_tri = 0; bad_cmd = 0;
    @(negedge clk);
    family = f; limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lim != '0) chk("R1 bus reset request one cycle after start", {61'b0, prim_req, prim_op}, 64'h4);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (cyc == poke) begin start = 1'b1; family = 8'h3A; limit = 3'd1; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; family = f;
    if (!done) chk("R12 done within time", 64'h0, 64'h1);
    got_count = int'(count); got_err = int'(err); n_done = 1;
    repeat (4) begin
      @(negedge clk);
      if (done) n_done++;
    end
  endtask

  task automatic check_table(input string what, input int n);
    for (int k = 0; k < n; k++) begin
      rd_slot = SW'(k);
      #1;
      chk(what, rd_id, exp_ids[k]);
    end
  endtask

  task automatic t_reset;
    chk("R12 reset busy/done/err/req", {60'b0, busy, done, err, prim_req}, 64'h0);
    chk("R12 reset count", 64'(count), 64'h0);
  endtask

  task automatic t_empty;
    ndev = 0;
    run(8'h00, 3'd4, -1);
    chk("R2 empty bus count", 64'(got_count), 64'd0);
    chk("R2 empty bus err", 64'(got_err), 64'd0);
    chk("R2 one reset only", 64'(n_resets), 64'd1);
  endtask

  task automatic t_single;
    ndev = 1; dev[0] = mk_id(8'h28, 48'h0000_00A1_B2C3);
    build_exp(8'h00);
    run(8'h00, 3'd4, -1);
    chk("R3 single count", 64'(got_count), 64'd1);
    chk("R3 triplets per pass", 64'(n_tri), 64'd64);
    chk("R3 search byte value", 64'(bad_cmd), 64'd0);
    chk("R12 err cleared by new start", 64'(got_err), 64'd0);
    check_table("R3 single identifier bit order", 1);
  endtask

  task automatic t_multi;
    ndev = 3;
    dev[0] = mk_id(8'h28, 48'h0000_00A1_B2C3);
    dev[1] = mk_id(8'h28, 48'h0000_00A1_B2C4);
    dev[2] = mk_id(8'h10, 48'h0000_0012_3456);
    build_exp(8'h00);
    run(8'h00, 3'd4, 40);
    chk("R5 three devices count", 64'(got_count), 64'd3);
    chk("R5 one pass per device", 64'(n_resets), 64'd3);
    chk("R1 start while busy ignored, single done", 64'(n_done), 64'd1);
    check_table("R5 enumeration order", 3);
  endtask

  task automatic t_limit;
    ndev = 5;
    dev[3] = mk_id(8'h22, 48'h0000_0000_0777);
    dev[4] = mk_id(8'h28, 48'h0000_0F00_0001);
    build_exp(8'h00);
    run(8'h00, 3'd2, -1);
    chk("R10 limit 2 count", 64'(got_count), 64'd2);
    check_table("R10 limit 2 ids", 2);
    run(8'h00, 3'd7, -1);
    chk("R10 limit clamped to depth", 64'(got_count), 64'd4);
    chk("R10 clamp no error", 64'(got_err), 64'd0);
    check_table("R10 clamp ids", 4);
    run(8'h00, 3'd0, -1);
    chk("R10 limit 0 count", 64'(got_count), 64'd0);
    chk("R10 limit 0 no bus request", 64'(n_resets), 64'd0);
  endtask

  task automatic t_family;
    ndev = 3;
    dev[0] = mk_id(8'h28, 48'h0000_00A1_B2C3);
    dev[1] = mk_id(8'h10, 48'h0000_0012_3456);
    dev[2] = mk_id(8'h28, 48'h0000_0F00_0001);
    build_exp(8'h28);
    run(8'h28, 3'd4, -1);
    chk("R4 family filter count", 64'(got_count), 64'd2);
    check_table("R4 family filtered ids", 2);
    run(8'h3A, 3'd4, -1);
    chk("R7 absent family count", 64'(got_count), 64'd0);
    chk("R7 absent family no error", 64'(got_err), 64'd0);
    chk("R7 stops in first pass", 64'(n_resets), 64'd1);
  endtask

  task automatic t_lost;
    ndev = 1; dev[0] = mk_id(8'h10, 48'h0000_0012_3456);
    build_exp(8'h00);
    lose_at = 9;
    run(8'h00, 3'd4, -1);
    chk("R6 lost device restarts pass", 64'(n_resets), 64'd2);
    chk("R6 count after restart", 64'(got_count), 64'd1);
    chk("R6 no error", 64'(got_err), 64'd0);
    check_table("R6 identifier after restart", 1);
  endtask

  task automatic t_badcrc;
    ndev = 1; dev[0] = mk_id(8'h28, 48'h0000_00A1_B2C3) ^ {8'hFF, 56'h0};
    run(8'h00, 3'd4, -1);
    chk("R8 bad check byte not stored", 64'(got_count), 64'd0);
    chk("R9 retry cap passes", 64'(n_resets), 64'(RETRY_MAX + 1));
    chk("R9 error flag", 64'(got_err), 64'd1);
    chk("R9 single done", 64'(n_done), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_empty;
    t_single;
    t_multi;
    t_limit;
    t_family;
    t_lost;
    t_badcrc;
    t_single;
    chk("R11 request held stable until ack", 64'(hold_bad), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule